// File: doc/BRIEF.md
# Two-Way Doorbell Mailbox

This block lets two processors, called side A and side B, pass short messages to each other. It holds two 64-bit message words, one for each direction. The sender of a direction writes the payload and then the upper half of the word with the busy flag (bit 63) set. This raises a maskable interrupt at the receiver. The receiver reads the word and writes the upper half back with bit 63 clear, which releases the register. In the same write it may set the done flag (bit 62), and that raises a maskable completion interrupt at the sender. While a word is busy, its sender cannot overwrite it. A write attempted during that time is dropped and recorded in a sticky overrun bit. The block does not interpret the payload (bits 61:0) or the message code held in its low 30 bits.

Each side has its own 32-bit register port. The port has a word offset, a write strobe, write data and read data. The map is relative to the side making the access, so both sides run the same driver code. Offset 0 is the low half of the outgoing word and offset 1 its high half. Offset 2 is the low half of the incoming word and offset 3 its high half. Offset 4 is the interrupt mask and offset 5 the overrun status. There is no data stream and no back-pressure. Every write completes at the next rising clock edge. Read data is combinational from the offset and reflects every write made up to the last edge.

Top module: `ipc_doorbell_mbox`

## Requirements
- R1: After reset, both message words, both masks and both overrun bits are zero, all four interrupt outputs are low, and every offset reads as zero.
- R2: A side that writes offset 0 or 1 while its outgoing busy flag is clear stores the write data into bits 31:0 or 63:32 of the outgoing word. Write data bit 31 goes into busy (bit 63) and bit 30 into done (bit 62). The other side reads the same value at offsets 2 and 3.
- R3: A write to offset 0 or 1 while the outgoing busy flag is set is dropped, and the stored word keeps its value.
- R4: A dropped write sets the sender's overrun bit, which reads as bit 0 at offset 5. Writing 1 to that bit clears it, and writing 0 leaves it unchanged.
- R5: A write to offset 3 by the receiver clears busy when data bit 31 is 0 and leaves busy unchanged when that bit is 1. Data bit 30 is written into done. Payload bits 61:0 are not changed by this write.
- R6: A write to offset 2 (incoming low half) has no effect.
- R7: The message interrupt of a side equals its incoming busy flag AND mask bit 0. The done interrupt of a side equals its outgoing done flag AND mask bit 1. Each interrupt is low in the cycle after its flag clears.
- R8: Offset 4 stores write data bits 1:0 as the mask and reads back with bits 31:2 zero.
- R9: When the sender's write to a non-busy word and the receiver's offset-3 write to that same word fall in the same cycle, the sender's write is applied and the receiver's is dropped.
- R10: Offsets 6 and 7 read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_addr | input | 3 | Side A word offset |
| a_wr_en | input | 1 | Side A write strobe |
| a_wdata | input | BUS_W | Side A write data |
| a_rdata | output | BUS_W | Side A read data for a_addr |
| b_addr | input | 3 | Side B word offset |
| b_wr_en | input | 1 | Side B write strobe |
| b_wdata | input | BUS_W | Side B write data |
| b_rdata | output | BUS_W | Side B read data for b_addr |
| a_irq_msg | output | 1 | Message waiting for side A |
| a_irq_done | output | 1 | Side B finished side A's request |
| b_irq_msg | output | 1 | Message waiting for side B |
| b_irq_done | output | 1 | Side A finished side B's request |

## Verification
The bench runs both directions through eight payloads and all four mask values. For each it derives the expected word and interrupt levels from the write data. It aims at a sender overwrite while busy; a design that let that through would corrupt a message the receiver has not yet read and would leave overrun clear. It also checks a receiver write-back with bit 31 set, which must not release the word, and a write to the incoming low half, which a careless decoder would let alter the payload. A sender write and a receiver acknowledge landing in the same cycle would lose the new message if the design let the receiver win. The check on interrupt level one cycle after a clear would catch a design that registers the interrupt one stage late.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;
  localparam int OFS_W = 3;
  localparam int NUM_SIDES = 2;

  typedef enum logic [OFS_W-1:0] {
    OFS_OUT_LO = 3'd0,
    OFS_OUT_HI = 3'd1,
    OFS_IN_LO  = 3'd2,
    OFS_IN_HI  = 3'd3,
    OFS_MASK   = 3'd4,
    OFS_OVR    = 3'd5
  } mbox_ofs_e;

  typedef struct packed {
    logic done_en;
    logic msg_en;
  } irq_mask_t;
endpackage

// File: rtl/ipc_msg_chan.sv
module ipc_msg_chan
  import ipc_mbox_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               snd_we_lo,
  input  logic               snd_we_hi,
  input  logic [BUS_W-1:0]   snd_wdata,
  input  logic               rcv_we_hi,
  input  logic [BUS_W-1:0]   rcv_wdata,
  input  logic               ovr_clr,
  output logic [2*BUS_W-1:0] msg,
  output logic               overrun
);
  localparam int MSG_W    = 2 * BUS_W;
  localparam int BUSY_BIT = MSG_W - 1;
  localparam int DONE_BIT = MSG_W - 2;

  logic [MSG_W-1:0] word_q;
  logic             ovr_q;
  logic             busy;
  logic             snd_req;
  logic             snd_ok;
  logic             snd_drop;
  logic             rcv_ok;

  always_comb begin
    busy     = word_q[BUSY_BIT];
    snd_req  = snd_we_lo | snd_we_hi;
    snd_ok   = snd_req & ~busy;
    snd_drop = snd_req & busy;
    // a sender write that is accepted takes precedence over the acknowledge
    rcv_ok   = rcv_we_hi & ~snd_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (snd_ok) begin
      if (snd_we_lo) word_q[BUS_W-1:0]     <= snd_wdata;
      else           word_q[MSG_W-1:BUS_W] <= snd_wdata;
    end else if (rcv_ok) begin
      // receiver may only release busy, never raise it
      word_q[BUSY_BIT] <= busy & rcv_wdata[BUS_W-1];
      word_q[DONE_BIT] <= rcv_wdata[BUS_W-2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovr_q <= 1'b0;
    else if (snd_drop) ovr_q <= 1'b1;
    else if (ovr_clr)  ovr_q <= 1'b0;
  end

  assign msg     = word_q;
  assign overrun = ovr_q;
endmodule

// File: rtl/ipc_bus_port.sv
module ipc_bus_port
  import ipc_mbox_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [OFS_W-1:0]   addr,
  input  logic               wr_en,
  input  logic [BUS_W-1:0]   wdata,
  input  logic [2*BUS_W-1:0] out_msg,
  input  logic [2*BUS_W-1:0] in_msg,
  input  logic               out_ovr,
  output logic               out_we_lo,
  output logic               out_we_hi,
  output logic               in_we_hi,
  output logic               ovr_clr,
  output irq_mask_t          mask,
  output logic [BUS_W-1:0]   rdata
);
  localparam int MSG_W = 2 * BUS_W;

  irq_mask_t mask_q;

  always_comb begin
    out_we_lo = wr_en && (addr == OFS_OUT_LO);
    out_we_hi = wr_en && (addr == OFS_OUT_HI);
    in_we_hi  = wr_en && (addr == OFS_IN_HI);
    ovr_clr   = wr_en && (addr == OFS_OVR) && wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               mask_q <= '0;
    else if (wr_en && (addr == OFS_MASK))     mask_q <= irq_mask_t'(wdata[1:0]);
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_OUT_LO: rdata = out_msg[BUS_W-1:0];
      OFS_OUT_HI: rdata = out_msg[MSG_W-1:BUS_W];
      OFS_IN_LO:  rdata = in_msg[BUS_W-1:0];
      OFS_IN_HI:  rdata = in_msg[MSG_W-1:BUS_W];
      OFS_MASK:   rdata[1:0] = mask_q;
      OFS_OVR:    rdata[0] = out_ovr;
      default:    rdata = '0;
    endcase
  end

  assign mask = mask_q;
endmodule

// File: rtl/ipc_doorbell_mbox.sv
module ipc_doorbell_mbox
  import ipc_mbox_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       a_addr,
  input  logic             a_wr_en,
  input  logic [BUS_W-1:0] a_wdata,
  output logic [BUS_W-1:0] a_rdata,
  input  logic [2:0]       b_addr,
  input  logic             b_wr_en,
  input  logic [BUS_W-1:0] b_wdata,
  output logic [BUS_W-1:0] b_rdata,
  output logic             a_irq_msg,
  output logic             a_irq_done,
  output logic             b_irq_msg,
  output logic             b_irq_done
);
  localparam int MSG_W    = 2 * BUS_W;
  localparam int BUSY_BIT = MSG_W - 1;
  localparam int DONE_BIT = MSG_W - 2;

  // index 0 = side A, index 1 = side B; channel i carries side i's outgoing word
  logic [OFS_W-1:0] side_addr  [NUM_SIDES];
  logic             side_we    [NUM_SIDES];
  logic [BUS_W-1:0] side_wdata [NUM_SIDES];
  logic [BUS_W-1:0] side_rdata [NUM_SIDES];
  logic             we_out_lo  [NUM_SIDES];
  logic             we_out_hi  [NUM_SIDES];
  logic             we_in_hi   [NUM_SIDES];
  logic             clr_ovr    [NUM_SIDES];
  irq_mask_t        side_mask  [NUM_SIDES];
  logic [MSG_W-1:0] chan_msg   [NUM_SIDES];
  logic             chan_ovr   [NUM_SIDES];
  logic             irq_msg    [NUM_SIDES];
  logic             irq_done   [NUM_SIDES];

  assign side_addr[0]  = a_addr;
  assign side_we[0]    = a_wr_en;
  assign side_wdata[0] = a_wdata;
  assign side_addr[1]  = b_addr;
  assign side_we[1]    = b_wr_en;
  assign side_wdata[1] = b_wdata;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    localparam int PEER = NUM_SIDES - 1 - s;

    ipc_msg_chan #(.BUS_W(BUS_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .snd_we_lo (we_out_lo[s]),
      .snd_we_hi (we_out_hi[s]),
      .snd_wdata (side_wdata[s]),
      .rcv_we_hi (we_in_hi[PEER]),
      .rcv_wdata (side_wdata[PEER]),
      .ovr_clr   (clr_ovr[s]),
      .msg       (chan_msg[s]),
      .overrun   (chan_ovr[s])
    );

    ipc_bus_port #(.BUS_W(BUS_W)) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (side_addr[s]),
      .wr_en     (side_we[s]),
      .wdata     (side_wdata[s]),
      .out_msg   (chan_msg[s]),
      .in_msg    (chan_msg[PEER]),
      .out_ovr   (chan_ovr[s]),
      .out_we_lo (we_out_lo[s]),
      .out_we_hi (we_out_hi[s]),
      .in_we_hi  (we_in_hi[s]),
      .ovr_clr   (clr_ovr[s]),
      .mask      (side_mask[s]),
      .rdata     (side_rdata[s])
    );

    assign irq_msg[s]  = chan_msg[PEER][BUSY_BIT] & side_mask[s].msg_en;
    assign irq_done[s] = chan_msg[s][DONE_BIT]    & side_mask[s].done_en;
  end

  assign a_rdata    = side_rdata[0];
  assign b_rdata    = side_rdata[1];
  assign a_irq_msg  = irq_msg[0];
  assign a_irq_done = irq_done[0];
  assign b_irq_msg  = irq_msg[1];
  assign b_irq_done = irq_done[1];
endmodule

// File: rtl/ipc_doorbell_chk.sv
module ipc_doorbell_chk #(
  parameter int BUS_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2:0]         a_addr,
  input logic               a_wr_en,
  input logic [2:0]         b_addr,
  input logic               b_wr_en,
  input logic               b_irq_msg,
  input logic               a_irq_done,
  input logic [2*BUS_W-1:0] msg_ab,
  input logic               ovr_ab
);
  localparam int BUSY_BIT = 2 * BUS_W - 1;
  localparam int DONE_BIT = 2 * BUS_W - 2;

  logic a_snd, b_ack, b_lo;
  assign a_snd = a_wr_en && (a_addr < 3'd2);
  assign b_ack = b_wr_en && (b_addr == 3'd3);
  assign b_lo  = b_wr_en && (b_addr == 3'd2);

  a_r3_busy_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    a_snd && msg_ab[BUSY_BIT] && !b_ack |=> $stable(msg_ab));

  a_r4_overrun_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    a_snd && msg_ab[BUSY_BIT] |=> ovr_ab);

  a_r5_busy_only_by_sender: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_ab[BUSY_BIT] && !(a_wr_en && a_addr == 3'd1) |=> !msg_ab[BUSY_BIT]);

  a_r6_in_lo_inert: assert property (@(posedge clk) disable iff (!rst_n)
    b_lo && !a_wr_en |=> $stable(msg_ab));

  a_r7_msg_irq_drops: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(msg_ab[BUSY_BIT]) |-> !b_irq_msg);

  a_r7_done_irq_drops: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(msg_ab[DONE_BIT]) |-> !a_irq_done);
endmodule

bind ipc_doorbell_mbox ipc_doorbell_chk #(.BUS_W(BUS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .a_addr     (a_addr),
  .a_wr_en    (a_wr_en),
  .b_addr     (b_addr),
  .b_wr_en    (b_wr_en),
  .b_irq_msg  (b_irq_msg),
  .a_irq_done (a_irq_done),
  .msg_ab     (chan_msg[0]),
  .ovr_ab     (chan_ovr[0])
);

// File: tb/sim_ipc_doorbell_mbox.sv
module sim_ipc_doorbell_mbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  a_addr = '0, b_addr = '0;
  logic        a_wr_en = 1'b0, b_wr_en = 1'b0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic [31:0] a_rdata, b_rdata;
  logic        a_irq_msg, a_irq_done, b_irq_msg, b_irq_done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ipc_doorbell_mbox #(.BUS_W(32)) u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    a_wr_en = 1'b0; b_wr_en = 1'b0;
  endtask

  task automatic drive(int p, logic [2:0] ofs, logic [31:0] d);
    if (p == 0) begin a_addr = ofs; a_wdata = d; a_wr_en = 1'b1; end
    else        begin b_addr = ofs; b_wdata = d; b_wr_en = 1'b1; end
  endtask

  task automatic wr(int p, logic [2:0] ofs, logic [31:0] d);
    @(negedge clk); drive(p, ofs, d);
    @(negedge clk); idle();
  endtask

  task automatic rd(int p, logic [2:0] ofs, output logic [31:0] v);
    @(negedge clk); idle();
    if (p == 0) a_addr = ofs; else b_addr = ofs;
    #1 v = (p == 0) ? a_rdata : b_rdata;
  endtask

  function automatic logic irq_m(int p);
    return (p == 0) ? a_irq_msg : b_irq_msg;
  endfunction

  function automatic logic irq_d(int p);
    return (p == 0) ? a_irq_done : b_irq_done;
  endfunction

  initial begin
    logic [31:0] v, lo, hi;
    int r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int p = 0; p < 2; p++)
      for (int o = 0; o < 8; o++) begin
        rd(p, 3'(o), v); chk("R1 reset read", v, 0);
      end
    chk("R1 irq low", {28'd0, a_irq_msg, a_irq_done, b_irq_msg, b_irq_done}, 0);

    for (int s = 0; s < 2; s++) begin
      r = 1 - s;
      wr(r, 4, 32'h1);  // receiver: message interrupt enabled
      wr(s, 4, 32'h2);  // sender: done interrupt enabled
      for (int k = 0; k < 8; k++) begin
        lo = (32'h1357_9BDF * (k + 1)) ^ 32'(s);
        hi = {2'b10, 30'(k * 91 + 5 + s)};
        wr(s, 0, lo);
        chk("R7 no irq before busy", {31'd0, irq_m(r)}, 0);
        wr(s, 1, hi);
        rd(r, 2, v); chk("R2 incoming low", v, lo);
        rd(r, 3, v); chk("R2 incoming high", v, hi);
        rd(s, 0, v); chk("R2 outgoing low", v, lo);
        chk("R7 msg irq raised", {31'd0, irq_m(r)}, 1);
        // blocked overwrites
        wr(s, 0, ~lo);
        wr(s, 1, 32'h0);
        rd(r, 2, v); chk("R3 low kept", v, lo);
        rd(r, 3, v); chk("R3 high kept", v, hi);
        rd(s, 5, v); chk("R4 overrun set", v, 1);
        wr(s, 5, 32'hFFFF_FFFE);
        rd(s, 5, v); chk("R4 write0 keeps", v, 1);
        wr(s, 5, 32'h1);
        rd(s, 5, v); chk("R4 write1 clears", v, 0);
        // receiver side
        wr(r, 2, 32'hDEAD_BEEF);
        rd(r, 2, v); chk("R6 in low ignored", v, lo);
        wr(r, 3, 32'hC000_0000 | 32'(k));
        rd(r, 3, v); chk("R5 busy held done set", v, {2'b11, hi[29:0]});
        chk("R7 done irq", {31'd0, irq_d(s)}, 1);
        @(negedge clk); drive(r, 3, 32'h0);
        @(negedge clk); idle();
        chk("R7 msg irq falls", {31'd0, irq_m(r)}, 0);
        chk("R7 done irq falls", {31'd0, irq_d(s)}, 0);
        rd(s, 1, v); chk("R5 payload kept", v, {2'b00, hi[29:0]});
        rd(s, 0, v); chk("R5 low kept", v, lo);
      end
      // mask sweep
      wr(s, 1, 32'hC000_0077);
      for (int m = 0; m < 4; m++) begin
        wr(r, 4, 32'(m)); wr(s, 4, 32'(m));
        rd(s, 4, v);
        chk("R7 msg irq vs mask", {31'd0, irq_m(r)}, 32'(m & 1));
        chk("R7 done irq vs mask", {31'd0, irq_d(s)}, 32'((m >> 1) & 1));
      end
      wr(r, 3, 32'h0);
      // same-cycle sender and acknowledge
      @(negedge clk); drive(s, 1, 32'h8000_0AAA); drive(r, 3, 32'h4000_0000);
      @(negedge clk); idle();
      rd(r, 3, v); chk("R9 sender wins", v, 32'h8000_0AAA);
      wr(r, 3, 32'h0);
      // mask width
      wr(s, 4, 32'hFFFF_FFFF);
      rd(s, 4, v); chk("R8 mask readback", v, 3);
      wr(s, 4, 32'h0);
      rd(s, 4, v); chk("R8 mask cleared", v, 0);
      // unmapped
      rd(s, 0, lo);
      wr(s, 6, 32'hFFFF_FFFF); wr(s, 7, 32'hFFFF_FFFF);
      rd(s, 6, v); chk("R10 ofs6 zero", v, 0);
      rd(s, 7, v); chk("R10 ofs7 zero", v, 0);
      rd(s, 0, v); chk("R10 no side effect", v, lo);
      rd(s, 4, v); chk("R10 mask untouched", v, 0);
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule